// File: doc/BRIEF.md
# Command-Controlled SPI Master Engine

This block is a serial peripheral interface master that moves one character at a time. Software controls it through a write-only command word. The word carries four one-shot strobes: enable, disable, soft reset and release-after-next. A separate configuration write sets three things: master or slave operation, chip-select hold, and the serial clock divider. Transmit characters enter through a valid/ready stream. Each character is shifted out MSB first on MOSI in clock mode 0, while MISO is sampled into a receive character. That receive character comes out as a single-cycle valid pulse.

The engine drives one active-low chip select. Without hold, chip select is released after every character. With hold, it stays asserted between characters until a release-after-next strobe is served, or until hold or the enabled state goes away. A disable that arrives during a character is deferred until that character has finished. While the engine is disabled or in slave mode, every pin output enable is low. Soft reset acts at once, aborts any character in flight and returns the engine to slave mode.

Back-pressure: a character is taken on a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` does not depend on `tx_valid`. The receive side has no ready signal, and `rx_data` stays stable until the next received character.

Top module: `spi_cmd_master`

## Requirements
- R1: After `rst_n` is released, `enabled`, `busy`, `tx_ready` and all three output enables are 0 and `cs_n_o` is 1. The engine is in slave mode and the divider is 0.
- R2: The command word is decoded only on `cmd_wr`: bit 0 enables, bit 1 disables, bit 7 is soft reset and bit 24 is release-after-next. A bit written as 0 has no effect, and so does any other bit.
- R3: When enable and disable are both 1 in one command write and no character is active, the engine ends up disabled.
- R4: A disable written while a character is active leaves `enabled` at 1 and forces `tx_ready` low until that character's final cycle, and `enabled` falls at that point. A disable written in the final cycle of a character takes effect in that same cycle.
- R5: `sck_oe`, `mosi_oe` and `cs_oe` are high only while the engine is enabled and in master mode. Chip select is released whenever the engine is disabled.
- R6: Soft reset (bit 7) takes effect at the next clock edge, even mid-character. It clears `enabled`, `busy`, pending flags, hold, divider and master mode, produces no `rx_valid` for the aborted character, and overrides other bits in the same write.
- R7: A character is 8 bits, MSB first, in mode 0: MOSI changes on the falling SCK edge, MISO is sampled on the rising edge, and SCK idles low. `rx_data` holds the sampled bits, and `rx_valid` pulses for one cycle at the last sample.
- R8: `tx_ready` is high only when the engine is idle, enabled, in master mode and has no pending disable. A character starts only on a `tx_valid`/`tx_ready` handshake.
- R9: With hold off, `cs_n_o` returns to 1 after every character.
- R10: With hold on, `cs_n_o` stays 0 between characters. A release-after-next strobe makes it return to 1 after the next character that completes, and the strobe is then cleared. Turning hold off while idle releases chip select.
- R11: Each SCK half period lasts `cfg_div`+1 clock cycles.
- R12: `busy` is high from the cycle chip select is asserted for a character until SCK has fallen after its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_master | input | 1 | 1 = master mode |
| cfg_cs_hold | input | 1 | 1 = hold chip select between characters |
| cfg_div | input | DIV_W | SCK half period minus one, in clock cycles |
| tx_valid | input | 1 | Transmit character valid |
| tx_ready | output | 1 | Engine can take a character |
| tx_data | input | CHAR_W | Transmit character |
| rx_valid | output | 1 | One-cycle pulse: received character available |
| rx_data | output | CHAR_W | Received character |
| enabled | output | 1 | Enabled state after any deferred disable |
| busy | output | 1 | Character in progress |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| cs_n_o | output | 1 | Active-low chip select |
| cs_oe | output | 1 | Chip select output enable |
| miso_i | input | 1 | Serial data in |

## Verification
The disable command and the end of a character can land on the same clock edge. The control logic must then decide at once whether to defer or to act. The bench provokes this by waiting for the `rx_valid` pulse of a character and issuing the disable on the very next edge, which is when SCK falls and the character ends. The bench expects `enabled`, `busy` and `tx_ready` to be low one cycle later; a wrongly deferred disable would leave `enabled` stuck high. The bench also drives a release-after-next strobe and a soft reset while characters are in flight.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned CMD_EN_BIT   = 0;
  localparam int unsigned CMD_DIS_BIT  = 1;
  localparam int unsigned CMD_RST_BIT  = 7;
  localparam int unsigned CMD_LAST_BIT = 24;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_TAIL} sh_state_t;

  typedef struct packed {
    logic en;
    logic dis;
    logic rst;
    logic last;
  } cmd_t;
endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_data,
  input  logic             cfg_wr,
  input  logic             cfg_master,
  input  logic             cfg_cs_hold,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             active,
  input  logic             char_done,
  output logic             soft_rst,
  output logic             enabled,
  output logic             master,
  output logic             cs_hold,
  output logic [DIV_W-1:0] div,
  output logic             dis_pending,
  output logic             last_pending
);
  cmd_t cmd;
  logic unused_cmd_bits;

  always_comb begin
    cmd.en   = cmd_wr & cmd_data[CMD_EN_BIT];
    cmd.dis  = cmd_wr & cmd_data[CMD_DIS_BIT];
    cmd.rst  = cmd_wr & cmd_data[CMD_RST_BIT];
    cmd.last = cmd_wr & cmd_data[CMD_LAST_BIT];
  end
  assign unused_cmd_bits = ^cmd_data;
  assign soft_rst = cmd.rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled      <= 1'b0;
      master       <= 1'b0;
      cs_hold      <= 1'b0;
      div          <= '0;
      dis_pending  <= 1'b0;
      last_pending <= 1'b0;
    end else if (cmd.rst) begin
      enabled      <= 1'b0;
      master       <= 1'b0;
      cs_hold      <= 1'b0;
      div          <= '0;
      dis_pending  <= 1'b0;
      last_pending <= 1'b0;
    end else begin
      if (cfg_wr) begin
        master  <= cfg_master;
        cs_hold <= cfg_cs_hold;
        div     <= cfg_div;
      end
      if (cmd.dis) begin
        if (active && !char_done) begin
          dis_pending <= 1'b1;
        end else begin
          enabled     <= 1'b0;
          dis_pending <= 1'b0;
        end
      end else if (cmd.en) begin
        enabled     <= 1'b1;
        dis_pending <= 1'b0;
      end else if (char_done && dis_pending) begin
        enabled     <= 1'b0;
        dis_pending <= 1'b0;
      end
      if (cmd.last) begin
        last_pending <= 1'b1;
      end else if (char_done) begin
        last_pending <= 1'b0;
      end
    end
  end

  // R4: enabled only drops when no character runs, at its end, or on soft reset
  assert_defer_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enabled) |-> $past(!active || char_done || soft_rst));

  // R3: simultaneous enable and disable with no character active leaves it disabled
  assert_disable_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.en && cmd.dis && !active) |=> !enabled);
endmodule

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R11: a half period never exceeds the programmed length
  assert_tick_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |-> (cnt <= div));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tick,
  input  logic              cs_allow,
  input  logic              cs_hold,
  input  logic              last_pending,
  input  logic              miso,
  output logic              busy,
  output logic              char_done,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              rx_valid,
  output logic [CHAR_W-1:0] rx_data
);
  localparam int unsigned CNT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAR_W - 1);

  sh_state_t         state;
  logic [CHAR_W-2:0] tx_rest;
  logic [CHAR_W-2:0] rx_part;
  logic [CNT_W-1:0]  bit_idx;

  assign busy      = (state != SH_IDLE);
  assign char_done = (state == SH_TAIL) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      tx_rest  <= '0;
      rx_part  <= '0;
      bit_idx  <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      cs_n     <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (clr) begin
      state    <= SH_IDLE;
      tx_rest  <= '0;
      rx_part  <= '0;
      bit_idx  <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      cs_n     <= 1'b1;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        SH_IDLE: begin
          if (start) begin
            state   <= SH_SHIFT;
            tx_rest <= tx_data[CHAR_W-2:0];
            mosi    <= tx_data[CHAR_W-1];
            cs_n    <= 1'b0;
            bit_idx <= '0;
            sck     <= 1'b0;
          end else if (!cs_allow || !cs_hold) begin
            cs_n <= 1'b1;
          end
        end
        SH_SHIFT: begin
          if (tick) begin
            if (!sck) begin
              sck     <= 1'b1;
              rx_part <= {rx_part[CHAR_W-3:0], miso};
              if (bit_idx == LAST_IDX) begin
                rx_data  <= {rx_part, miso};
                rx_valid <= 1'b1;
                state    <= SH_TAIL;
              end
            end else begin
              sck     <= 1'b0;
              mosi    <= tx_rest[CHAR_W-2];
              tx_rest <= tx_rest << 1;
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        SH_TAIL: begin
          if (tick) begin
            sck   <= 1'b0;
            state <= SH_IDLE;
            if (!cs_hold || last_pending || !cs_allow) begin
              cs_n <= 1'b1;
            end
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  // R12: chip select is asserted throughout a character
  assert_busy_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);
  // R7: SCK idles low
  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R7: received character is a single-cycle pulse
  assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R6: soft reset aborts at once with no result
  assert_swrst_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && cs_n && !rx_valid));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_data,
  input  logic              cfg_wr,
  input  logic              cfg_master,
  input  logic              cfg_cs_hold,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [CHAR_W-1:0] rx_data,
  output logic              enabled,
  output logic              busy,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  output logic              cs_n_o,
  output logic              cs_oe,
  input  logic              miso_i
);
  logic             soft_rst;
  logic             master;
  logic             cs_hold;
  logic [DIV_W-1:0] div;
  logic             dis_pending;
  logic             last_pending;
  logic             char_done;
  logic             tick;
  logic             drive_pins;
  logic             start;

  assign drive_pins = enabled && master;
  assign tx_ready   = drive_pins && !dis_pending && !busy && !soft_rst;
  assign start      = tx_valid && tx_ready;
  assign sck_oe     = drive_pins;
  assign mosi_oe    = drive_pins;
  assign cs_oe      = drive_pins;

  spi_cmd_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_data     (cmd_data),
    .cfg_wr       (cfg_wr),
    .cfg_master   (cfg_master),
    .cfg_cs_hold  (cfg_cs_hold),
    .cfg_div      (cfg_div),
    .active       (busy),
    .char_done    (char_done),
    .soft_rst     (soft_rst),
    .enabled      (enabled),
    .master       (master),
    .cs_hold      (cs_hold),
    .div          (div),
    .dis_pending  (dis_pending),
    .last_pending (last_pending)
  );

  spi_sck_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_rst),
    .run   (busy),
    .div   (div),
    .tick  (tick)
  );

  spi_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (soft_rst),
    .start        (start),
    .tx_data      (tx_data),
    .tick         (tick),
    .cs_allow     (drive_pins),
    .cs_hold      (cs_hold),
    .last_pending (last_pending),
    .miso         (miso_i),
    .busy         (busy),
    .char_done    (char_done),
    .sck          (sck_o),
    .mosi         (mosi_o),
    .cs_n         (cs_n_o),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data)
  );

  // R8: a character only starts after a handshake while enabled as master
  assert_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enabled && master && tx_valid && !dis_pending));
  // R5: chip select is released once the engine is disabled and idle
  assert_cs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !busy) |=> cs_n_o);
endmodule

// File: tb/sim_spi_cmd_master.sv
`timescale 1ns/1ps
module sim_spi_cmd_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_master = 1'b0;
  logic        cfg_cs_hold = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = '0;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        enabled, busy;
  logic        sck_o, sck_oe, mosi_o, mosi_oe, cs_n_o, cs_oe;
  logic        miso_i;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] q_tx[$];
  logic [7:0] q_rx[$];

  // slave model: byte shifted out on falling SCK, MOSI captured on rising SCK
  logic [7:0] sl_byte = '0;
  int         sl_base = 0;
  int         fall_cnt = 0;
  logic [7:0] mosi_cap = '0;
  int         sl_idx;

  always #10 clk = ~clk;

  always @(negedge sck_o) fall_cnt <= fall_cnt + 1;
  always @(posedge sck_o) mosi_cap <= {mosi_cap[6:0], mosi_o};
  assign sl_idx = fall_cnt - sl_base;
  assign miso_i = (sl_idx >= 0 && sl_idx < 8) ? sl_byte[7 - sl_idx] : 1'b0;

  spi_cmd_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .cfg_wr(cfg_wr), .cfg_master(cfg_master), .cfg_cs_hold(cfg_cs_hold),
    .cfg_div(cfg_div), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .enabled(enabled), .busy(busy), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .cs_n_o(cs_n_o), .cs_oe(cs_oe),
    .miso_i(miso_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = w;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0;
  endtask

  task automatic write_cfg(input bit m, input bit h, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_master = m; cfg_cs_hold = h; cfg_div = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // driver: hands a character over and records what the monitor must see
  task automatic send(input logic [7:0] b, input bit expect_result);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    sl_byte = b ^ 8'hA5;
    sl_base = fall_cnt;
    if (expect_result) begin
      q_tx.push_back(b);
      q_rx.push_back(b ^ 8'hA5);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // monitor: compares each received character against the scoreboard (R7)
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (q_rx.size() == 0) begin
        chk(1'b0, "R6 unexpected rx_valid", rx_data, 0);
      end else begin
        logic [7:0] er, et;
        er = q_rx.pop_front();
        et = q_tx.pop_front();
        chk(rx_data == er, "R7 miso capture", rx_data, er);
        chk(mosi_cap == et, "R7 mosi bits", mosi_cap, et);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int hi_len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!enabled && !busy && !tx_ready, "R1 status", {enabled, busy, tx_ready}, 0);
    chk(!sck_oe && !mosi_oe && !cs_oe && cs_n_o, "R1 pins", {sck_oe, mosi_oe, cs_oe, cs_n_o}, 1);

    // R2 zero and unrelated bits have no effect
    write_cmd(32'h0000_0000);
    write_cmd(32'hFEFF_FF7C);
    chk(!enabled && !busy, "R2 no-effect bits", {enabled, busy}, 0);

    // R2/R5 enable while slave: enabled but pins not driven, no ready
    write_cmd(32'h0000_0001);
    chk(enabled, "R2 enable bit", enabled, 1);
    chk(!sck_oe && !tx_ready, "R5 slave pins off", {sck_oe, tx_ready}, 0);

    write_cfg(1'b1, 1'b0, 8'd0);
    chk(sck_oe && mosi_oe && cs_oe && tx_ready, "R8 master ready",
        {sck_oe, mosi_oe, cs_oe, tx_ready}, 4'hF);

    // R7/R9 characters without hold
    foreach (q_tx[i]) begin end
    send(8'h3C, 1'b1); wait_idle();
    chk(cs_n_o, "R9 cs released", cs_n_o, 1);
    send(8'h81, 1'b1); wait_idle();
    chk(cs_n_o, "R9 cs released", cs_n_o, 1);
    send(8'hFF, 1'b1); wait_idle();
    send(8'h00, 1'b1); wait_idle();

    // R11 half period with divider 2
    write_cfg(1'b1, 1'b0, 8'd2);
    send(8'h6B, 1'b1);
    chk(busy && !cs_n_o, "R12 busy at start", {busy, cs_n_o}, 2);
    @(negedge clk);
    while (!sck_o) @(negedge clk);
    hi_len = 0;
    while (sck_o) begin hi_len++; @(negedge clk); end
    chk(hi_len == 3, "R11 sck high length", hi_len, 3);
    wait_idle();
    write_cfg(1'b1, 1'b1, 8'd0);

    // R10 hold across characters, release after next
    send(8'h12, 1'b1); wait_idle();
    chk(!cs_n_o, "R10 cs held", cs_n_o, 0);
    send(8'h34, 1'b1);
    write_cmd(32'h0100_0000);
    chk(!cs_n_o && busy, "R10 still held mid char", {cs_n_o, busy}, 1);
    wait_idle();
    chk(cs_n_o, "R10 released after char", cs_n_o, 1);
    send(8'h56, 1'b1); wait_idle();
    chk(!cs_n_o, "R10 release strobe cleared", cs_n_o, 0);
    write_cfg(1'b1, 1'b0, 8'd0);
    @(negedge clk);
    chk(cs_n_o, "R10 hold off releases", cs_n_o, 1);

    // R4 deferred disable
    send(8'hC7, 1'b1);
    write_cmd(32'h0000_0002);
    chk(enabled && busy && !tx_ready, "R4 disable deferred", {enabled, busy, tx_ready}, 6);
    wait_idle();
    chk(!enabled, "R4 disabled after char", enabled, 0);
    chk(!sck_oe && !mosi_oe && !cs_oe && cs_n_o, "R5 pins off when disabled",
        {sck_oe, mosi_oe, cs_oe, cs_n_o}, 1);

    // R3 enable and disable together
    write_cmd(32'h0000_0001);
    write_cmd(32'h0000_0003);
    chk(!enabled, "R3 disable wins", enabled, 0);

    // R4 disable landing on the final cycle of a character
    write_cmd(32'h0000_0001);
    send(8'h9A, 1'b1);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    cmd_wr = 1'b1; cmd_data = 32'h0000_0002;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0;
    chk(!enabled && !busy && !tx_ready, "R4 same-cycle disable",
        {enabled, busy, tx_ready}, 0);

    // R6 soft reset mid character
    write_cmd(32'h0000_0001);
    send(8'hE4, 1'b0);
    repeat (4) @(negedge clk);
    write_cmd(32'h0000_0080);
    chk(!busy && !enabled && cs_n_o && !sck_oe, "R6 abort",
        {busy, enabled, cs_n_o, sck_oe}, 2);
    write_cmd(32'h0000_0001);
    chk(enabled && !tx_ready && !sck_oe, "R6 slave after reset",
        {enabled, tx_ready, sck_oe}, 4);
    write_cmd(32'h0000_0081);
    chk(!enabled, "R6 overrides enable", enabled, 0);
    repeat (30) @(negedge clk);
    chk(q_rx.size() == 0, "R7 scoreboard drained", q_rx.size(), 0);
    finish_run();
  end
endmodule